// File: doc/BRIEF.md
# Pulse-Gated Waveform Capture Controller

This block drives a fast 8-bit converter and an external sample RAM so that waveform samples are stored only while a randomly timed pulse is present, plus a programmable tail after the pulse ends. Between pulses nothing is written. This keeps the stored data small when pulses are narrow and sparse. The converter's conversion enable, the RAM write strobe, the write address and the write data all come from this block.

A controller starts a capture group with a single strobe. The strobe zeroes the write address and arms the block. Each captured pulse ends with a latched end address, so the controller can subtract consecutive end addresses to get the number of samples in each pulse. After a programmed number of pulses the block pauses and ignores further pulses until the next start strobe. The controller starts the next group only after it has moved the stored data out. If the RAM fills, writing stops and a sticky overflow flag is raised.

Top module: `pulse_capture_ctrl`

## Requirements
- R1: After reset the block is paused: `paused_o`=1, `ram_addr_o`=0, `overflow_o`=0, `end_valid_o`=0, and no writes or sample enables occur.
- R2: A one-cycle `group_start_i` zeroes the write address, clears the pulse count and `overflow_o`, and leaves the block armed (`paused_o`=0) from the next cycle.
- R3: While capturing, `sample_en_o` fires once every N cycles, with N = max(`rate_div_i`, MIN_DIV) and MIN_DIV = ceil(CLK_HZ / MAX_SAMPLE_HZ) (5 with the defaults of 100 MHz and 20 MHz). The first enable falls on the first capture cycle.
- R4: A rising edge of `pulse_i` sampled while armed opens the capture window from the next cycle. A pulse sampled high on H clock edges with delay setting D>0 gives a window of H+D cycles. The number of samples stored is ceil((H+D)/N).
- R5: Every write stores `adc_data_i` of that cycle on `ram_data_o` at `ram_addr_o`, and the address increases by exactly one after each write.
- R6: When a window closes, `end_valid_o` pulses for one cycle and `end_addr_o` holds the total number of samples written since the group start, including any write in the closing cycle.
- R7: With D=0 the window closes on the cycle in which the low level is first sampled (H cycles long). A rising edge during the tail resumes capture with no gap, and the whole span produces a single end record.
- R8: After `group_size_i` end records (a value of 0 acts as 1) the block pauses. Pulses seen while paused cause no writes and no end records.
- R9: A 2^AW sample capacity is enforced. After the write to the last location, no further writes occur, `overflow_o` sets on the next sample enable and stays set until the next start, and `end_addr_o` reports 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | Shaped pulse presence, synchronous |
| group_start_i | input | 1 | Clear address and arm a new capture group |
| rate_div_i | input | DIV_W | Sample period in clock cycles (clamped to MIN_DIV) |
| delay_i | input | DLY_W | Tail length after the falling edge, in cycles |
| group_size_i | input | GRP_W | Pulses per group before pausing |
| adc_data_i | input | DW | Converter output sample |
| sample_en_o | output | 1 | Converter conversion enable |
| ram_we_o | output | 1 | Sample RAM write strobe |
| ram_addr_o | output | AW | Sample RAM write address |
| ram_data_o | output | DW | Sample RAM write data |
| end_addr_o | output | AW+1 | Sample count at the close of the last window |
| end_valid_o | output | 1 | One-cycle marker of a new end address |
| paused_o | output | 1 | Group complete or idle; pulses ignored |
| overflow_o | output | 1 | Sticky: a sample was dropped because the RAM was full |

## Verification
On every cycle the assertions hold the local invariants. The address steps by one per write. Sample enables are never adjacent. A pause or an overflow stops writes, and end markers last one cycle. A start strobe clears the address and overflow. The window lengths, the divider clamp, the tail continuation on a re-rise, the group pause count and the per-pulse sample counts derived from end addresses depend on whole pulse sequences. Only the bench's sweeps over pulse width, tail delay and divider can show those, with expected counts computed arithmetically.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  typedef enum logic [1:0] {
    ST_PAUSED,
    ST_ARMED,
    ST_ACTIVE,
    ST_TAIL
  } cap_state_e;
endpackage

// File: rtl/pcap_rate_div.sv
module pcap_rate_div #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] period;

  always_comb begin
    period = (div_i < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_i;
    tick_o = gate_i && (cnt_q == '0);
  end

  // restart phase at every window so the first sample lands on its first cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!gate_i)                 cnt_q <= '0;
    else if (cnt_q >= period - 1'b1)  cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pcap_gate_fsm.sv
module pcap_gate_fsm
  import pcap_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int GRP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             start_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [GRP_W-1:0] group_size_i,
  output logic             gate_o,
  output logic             stop_o,
  output logic             paused_o
);
  cap_state_e       state_q, state_d;
  logic             pulse_q;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic [GRP_W:0]   grp_nxt;
  logic             stop;

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    grp_d   = grp_q;
    stop    = 1'b0;
    grp_nxt = {1'b0, grp_q} + 1'b1;
    unique case (state_q)
      ST_PAUSED: ;
      ST_ARMED:  if (pulse_i && !pulse_q) state_d = ST_ACTIVE;
      ST_ACTIVE: begin
        if (!pulse_i) begin
          if (delay_i == '0) stop = 1'b1;
          else begin
            state_d = ST_TAIL;
            dly_d   = delay_i;
          end
        end
      end
      ST_TAIL: begin
        if (pulse_i)            state_d = ST_ACTIVE;
        else if (dly_q <= 1)    stop    = 1'b1;
        else                    dly_d   = dly_q - 1'b1;
      end
      default: state_d = ST_PAUSED;
    endcase
    if (stop) begin
      grp_d   = grp_nxt[GRP_W-1:0];
      state_d = (grp_nxt >= {1'b0, group_size_i}) ? ST_PAUSED : ST_ARMED;
    end
    if (start_i) begin
      state_d = ST_ARMED;
      grp_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSED;
      pulse_q <= 1'b0;
      dly_q   <= '0;
      grp_q   <= '0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_i;
      dly_q   <= dly_d;
      grp_q   <= grp_d;
    end
  end

  assign gate_o   = (state_q == ST_ACTIVE) || (state_q == ST_TAIL);
  assign stop_o   = stop && !start_i;
  assign paused_o = (state_q == ST_PAUSED);
endmodule

// File: rtl/pcap_addr_ctr.sv
module pcap_addr_ctr #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic          stop_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [AW:0]   end_addr_o,
  output logic          end_valid_o,
  output logic          overflow_o
);
  logic [AW:0] wr_q, wr_nxt;
  logic        full;

  // count saturates at 2**AW; the MSB doubles as the full flag
  assign full   = wr_q[AW];
  assign we_o   = tick_i && !full;
  assign wr_nxt = wr_q + {{AW{1'b0}}, we_o};
  assign addr_o = wr_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q        <= '0;
      overflow_o  <= 1'b0;
      end_addr_o  <= '0;
      end_valid_o <= 1'b0;
    end else if (start_i) begin
      wr_q        <= '0;
      overflow_o  <= 1'b0;
      end_valid_o <= 1'b0;
    end else begin
      wr_q        <= wr_nxt;
      end_valid_o <= stop_i;
      if (tick_i && full) overflow_o <= 1'b1;
      if (stop_i)         end_addr_o <= wr_nxt;
    end
  end
endmodule

// File: rtl/pulse_capture_ctrl.sv
module pulse_capture_ctrl #(
  parameter int CLK_HZ        = 100_000_000,
  parameter int MAX_SAMPLE_HZ = 20_000_000,
  parameter int DIV_W         = 8,
  parameter int DLY_W         = 8,
  parameter int GRP_W         = 8,
  parameter int AW            = 10,
  parameter int DW            = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             group_start_i,
  input  logic [DIV_W-1:0] rate_div_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [GRP_W-1:0] group_size_i,
  input  logic [DW-1:0]    adc_data_i,
  output logic             sample_en_o,
  output logic             ram_we_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic [DW-1:0]    ram_data_o,
  output logic [AW:0]      end_addr_o,
  output logic             end_valid_o,
  output logic             paused_o,
  output logic             overflow_o
);
  localparam int MIN_DIV = (CLK_HZ + MAX_SAMPLE_HZ - 1) / MAX_SAMPLE_HZ;

  logic gate, stop, tick;

  pcap_gate_fsm #(.DLY_W(DLY_W), .GRP_W(GRP_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pulse_i      (pulse_i),
    .start_i      (group_start_i),
    .delay_i      (delay_i),
    .group_size_i (group_size_i),
    .gate_o       (gate),
    .stop_o       (stop),
    .paused_o     (paused_o)
  );

  pcap_rate_div #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate),
    .div_i  (rate_div_i),
    .tick_o (tick)
  );

  pcap_addr_ctr #(.AW(AW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (group_start_i),
    .tick_i      (tick),
    .stop_i      (stop),
    .we_o        (ram_we_o),
    .addr_o      (ram_addr_o),
    .end_addr_o  (end_addr_o),
    .end_valid_o (end_valid_o),
    .overflow_o  (overflow_o)
  );

  assign sample_en_o = tick;
  assign ram_data_o  = adc_data_i;
endmodule

// File: rtl/pcap_checker.sv
module pcap_checker #(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          group_start_i,
  input logic          sample_en_o,
  input logic          ram_we_o,
  input logic [AW-1:0] ram_addr_o,
  input logic          end_valid_o,
  input logic          paused_o,
  input logic          overflow_o
);
  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && !group_start_i && ram_addr_o != {AW{1'b1}})
      |=> ram_addr_o == AW'($past(ram_addr_o) + 1'b1));

  a_r5_we_needs_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> sample_en_o);

  a_r3_sample_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_o |=> !sample_en_o);

  a_r8_paused_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> (!ram_we_o && !sample_en_o));

  a_r9_no_write_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> !ram_we_o);

  a_r6_end_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_valid_o |=> !end_valid_o);

  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    group_start_i |=> (ram_addr_o == '0 && !overflow_o && !paused_o));
endmodule

bind pulse_capture_ctrl pcap_checker #(.AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .group_start_i (group_start_i),
  .sample_en_o   (sample_en_o),
  .ram_we_o      (ram_we_o),
  .ram_addr_o    (ram_addr_o),
  .end_valid_o   (end_valid_o),
  .paused_o      (paused_o),
  .overflow_o    (overflow_o)
);

// File: tb/pulse_capture_ctrl_tb_top.sv
module pulse_capture_ctrl_tb_top;
  localparam int AW      = 6;
  localparam int MIN_DIV = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pulse = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    div = 8'd5;
  logic [7:0]    dly = 8'd0;
  logic [7:0]    grp = 8'd8;
  logic [7:0]    adc = 8'd0;
  logic          sample_en, we, end_valid, paused, ovf;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;
  logic [AW:0]   end_addr;

  int checks = 0, fails = 0, cyc = 0;
  int exp_addr = 0, ev_n = 0, ev_last = 0;

  always #2 clk = ~clk;

  pulse_capture_ctrl #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .group_start_i(start),
    .rate_div_i(div), .delay_i(dly), .group_size_i(grp), .adc_data_i(adc),
    .sample_en_o(sample_en), .ram_we_o(we), .ram_addr_o(addr),
    .ram_data_o(wdata), .end_addr_o(end_addr), .end_valid_o(end_valid),
    .paused_o(paused), .overflow_o(ovf)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) adc = adc + 8'd37;

  // write and end-record monitor
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (we) begin
        check(addr == exp_addr[AW-1:0], "R5 write address", addr, exp_addr);
        check(wdata == adc, "R5 write data", wdata, adc);
        exp_addr++;
      end
      if (end_valid) begin
        ev_n++;
        ev_last = int'(end_addr);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_group();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    exp_addr = 0;
    ev_last  = 0;
  endtask

  task automatic do_pulse(input int h, input int low);
    @(negedge clk) pulse = 1'b1;
    wait_n(h);
    pulse = 1'b0;
    wait_n(low);
  endtask

  function automatic int eff_n(input int d);
    return (d < MIN_DIV) ? MIN_DIV : d;
  endfunction

  initial begin
    int divs[4] = '{0, 5, 6, 7};
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1 reset state
    check(paused == 1'b1, "R1 paused", paused, 1);
    check(addr == 0, "R1 address", addr, 0);
    check(ovf == 1'b0, "R1 overflow", ovf, 0);
    check(end_valid == 1'b0 && we == 1'b0 && sample_en == 1'b0, "R1 quiet", we, 0);
    do_pulse(4, 6);
    check(exp_addr == 0 && ev_n == 0, "R1 pulse ignored before start", exp_addr, 0);

    // sweep divider x tail delay x pulse width
    foreach (divs[i]) begin
      for (int d = 0; d < 4; d++) begin
        int n, base, n0, tot, w0;
        div = 8'(divs[i]);
        dly = 8'(d);
        grp = 8'd8;
        n   = eff_n(divs[i]);
        start_group();
        check(addr == 0 && paused == 1'b0 && ovf == 1'b0, "R2 start clears", addr, 0);
        tot = 0;
        for (int h = 1; h <= 8; h++) begin
          int exp_cnt;
          base = ev_last;
          n0   = ev_n;
          exp_cnt = (h + d + n - 1) / n;
          tot += exp_cnt;
          do_pulse(h, d + 4);
          check(ev_n == n0 + 1, "R6 one end record", ev_n - n0, 1);
          if (d == 0)
            check(ev_last - base == exp_cnt, "R7 zero delay sample count (R3/R4)", ev_last - base, exp_cnt);
          else
            check(ev_last - base == exp_cnt, "R4 sample count (R3)", ev_last - base, exp_cnt);
        end
        check(ev_last == tot, "R6 cumulative end address", ev_last, tot);
        check(exp_addr == tot, "R5 total writes", exp_addr, tot);
        check(paused == 1'b1, "R8 paused after group", paused, 1);
        n0 = ev_n;
        w0 = exp_addr;
        do_pulse(5, 8);
        check(ev_n == n0 && exp_addr == w0, "R8 pulse ignored while paused", exp_addr - w0, 0);
      end
    end

    // re-rise during tail
    begin
      int n0;
      div = 8'd5; dly = 8'd4; grp = 8'd8;
      start_group();
      n0 = ev_n;
      @(negedge clk) pulse = 1'b1;
      wait_n(3);  pulse = 1'b0;
      wait_n(2);  pulse = 1'b1;
      wait_n(4);  pulse = 1'b0;
      wait_n(10);
      check(ev_n == n0 + 1, "R7 single record on re-rise", ev_n - n0, 1);
      check(ev_last == 3, "R7 continuous window samples", ev_last, 3);
    end

    // group size zero acts as one
    begin
      div = 8'd6; dly = 8'd1; grp = 8'd0;
      start_group();
      do_pulse(6, 6);
      check(paused == 1'b1, "R8 group size 0 pauses after one", paused, 1);
      check(ev_last == 2, "R4 count with group size 0", ev_last, 2);
    end

    // overflow
    begin
      div = 8'd5; dly = 8'd0; grp = 8'd8;
      start_group();
      do_pulse(400, 6);
      check(exp_addr == (1 << AW), "R9 writes capped", exp_addr, 1 << AW);
      check(ev_last == (1 << AW), "R9 end address at capacity", ev_last, 1 << AW);
      check(ovf == 1'b1, "R9 overflow set", ovf, 1);
      wait_n(5);
      check(ovf == 1'b1, "R9 overflow sticky", ovf, 1);
      start_group();
      check(ovf == 1'b0 && addr == 0, "R2 start clears overflow", ovf, 0);
      do_pulse(2, 4);
      check(ev_last == 1 && exp_addr == 1, "R2 capture after overflow restart", ev_last, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule